// File: doc/BRIEF.md
# Debug System Bus Access Controller

This block is the bus master that a debug module uses to reach system memory without involving a processor. A debugger sets up an access through a small register window: one control/status word, one address word and a set of 32-bit data words that together span the bus width. A write to the lowest data word launches a bus write. When the read-on-address flag is set, a write to the address word launches a bus read. Read results land in the data words, where the debugger can fetch them.

Only one access is outstanding at a time. The request is a single-cycle pulse carrying the direction, address, size code and write data. The response is a single-cycle pulse carrying an error flag and read data. The controller shows a busy flag while an access is in flight. It records a sticky busy-violation flag when the debugger touches the data or address words too early. It keeps a 3-bit error code for failed accesses. While either flag holds a nonzero value, no new access starts.

The size code and the alignment are checked at the moment an access would start. An illegal combination at that moment records an error and sends nothing on the bus.

Top module: `sbx_ctrl`

## Requirements
- R1: After reset the status word (offset 0) reads the VERSION parameter in bits 31:29 and zero in every other bit. The address word (offset 1) and the data words read zero, and no request is issued.
- R2: Writing the status word stores the read-on-address flag (bit 20) and the size code (bits 19:17). Reading it back returns them in the same positions. The size codes are 0=8, 1=16, 2=32, 3=64 and 4=128 bits.
- R3: The busy flag (bit 21) reads 1 from the cycle after an access starts until the bus response has been accepted. Only one request is ever outstanding.
- R4: Data word k sits at offset 2+k. Writing data word 0 starts a bus write using the stored address, the stored size code and the full data vector, with the newly written word in bits 31:0.
- R5: When bit 20 is 1, writing the address word starts a bus read at the new address. A successful read response is stored into the data words, with word k taking bus bits 32k+31:32k.
- R6: At the moment an access would start, the size code is checked against the bus width and the address against alignment to that size. If the size is wider than the bus, or the address is misaligned, no request is sent and the error field (bits 14:12) becomes 3.
- R7: Each of these events sets the busy-violation flag (bit 22): reading a data word while busy, writing the address word while busy, or writing a data word while busy. Such writes are ignored, and the flag stays set until it is cleared.
- R8: While bit 22 is set, or while the error field is nonzero, no write to the address or data words starts an access. Such writes still update the stored address or data.
- R9: An error response ends the access, clears the busy flag and sets the error field to 2. The data words are not modified.
- R10: Bit 22 and the error bits are write-1-to-clear. Writing 1 to a bit of the error field, or to bit 22, clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Registered read value, valid the cycle after reg_rd |
| req_valid | output | 1 | One-cycle bus request pulse |
| req_write | output | 1 | Request is a write |
| req_addr | output | AW | Request address |
| req_size | output | 3 | Request size code |
| req_wdata | output | BUS_W | Request write data |
| rsp_valid | input | 1 | One-cycle response pulse |
| rsp_err | input | 1 | Response reports a bad address |
| rsp_rdata | input | BUS_W | Response read data |

## Verification
The assertions assume that the bus answers every request with exactly one response pulse. They also assume that no response arrives while the controller is idle, and that reg_wr and reg_rd are never both high in one cycle. The bench's bus model answers a request only after seeing it, with a programmable latency of at least one cycle. It delivers exactly one response per request. The register driver issues one strobe per cycle, so the stimulus never breaks these assumptions.

// File: rtl/sbx_pkg.sv
`timescale 1ns/1ps
package sbx_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFS_STAT = 3'd0;
  localparam logic [REG_AW-1:0] OFS_ADDR = 3'd1;
  localparam int OFS_DATA = 2;
  localparam int B_BERR = 22;
  localparam int B_ROA  = 20;
  localparam int B_SIZE = 17;
  localparam int B_ERR  = 12;
  localparam logic [2:0] ERR_NONE = 3'd0;
  localparam logic [2:0] ERR_BAD  = 3'd2;
  localparam logic [2:0] ERR_OTH  = 3'd3;
endpackage

// File: rtl/sbx_check.sv
`timescale 1ns/1ps
module sbx_check #(
  parameter int BUS_W = 64
) (
  input  logic [2:0] size,
  input  logic [3:0] addr_lo,
  output logic       ok
);
  localparam int MAX_SZ = $clog2(BUS_W / 8);
  logic size_ok;
  logic align_ok;

  always_comb begin
    size_ok  = (int'(size) <= MAX_SZ) && (size <= 3'd4);
    align_ok = 1'b1;
    for (int b = 0; b < 4; b++) begin
      if (b < int'(size) && addr_lo[b]) align_ok = 1'b0;
    end
    ok = size_ok && align_ok;
  end
endmodule

// File: rtl/sbx_data.sv
`timescale 1ns/1ps
module sbx_data #(
  parameter int NW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW-1:0]    wr_en,
  input  logic [31:0]      wr_word,
  input  logic             load,
  input  logic [NW*32-1:0] load_data,
  output logic [NW*32-1:0] q
);
  logic [31:0] word_q [NW];

  generate
    for (genvar i = 0; i < NW; i++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)            word_q[i] <= '0;
        else if (load)      word_q[i] <= load_data[i*32 +: 32];
        else if (wr_en[i])  word_q[i] <= wr_word;
      end
      assign q[i*32 +: 32] = word_q[i];
    end
  endgenerate
endmodule

// File: rtl/sbx_bus.sv
`timescale 1ns/1ps
module sbx_bus #(
  parameter int BUS_W = 64,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             st_write,
  input  logic [AW-1:0]    st_addr,
  input  logic [2:0]       st_size,
  input  logic [BUS_W-1:0] st_wdata,
  input  logic             rsp_valid,
  output logic             busy,
  output logic             done,
  output logic             req_valid,
  output logic             req_write,
  output logic [AW-1:0]    req_addr,
  output logic [2:0]       req_size,
  output logic [BUS_W-1:0] req_wdata
);
  assign done = busy && rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_size  <= '0;
      req_wdata <= '0;
    end else begin
      req_valid <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        req_valid <= 1'b1;
        req_write <= st_write;
        req_addr  <= st_addr;
        req_size  <= st_size;
        req_wdata <= st_wdata;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
    busy && !rsp_valid |=> busy);
  p_req_while_busy_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy);
  p_single_out_r3: assert property (@(posedge clk) disable iff (rst)
    busy && !rsp_valid |=> !req_valid);
endmodule

// File: rtl/sbx_ctrl.sv
`timescale 1ns/1ps
module sbx_ctrl
  import sbx_pkg::*;
#(
  parameter int         BUS_W   = 64,
  parameter int         AW      = 32,
  parameter logic [2:0] VERSION = 3'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              req_valid,
  output logic              req_write,
  output logic [AW-1:0]     req_addr,
  output logic [2:0]        req_size,
  output logic [BUS_W-1:0]  req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [BUS_W-1:0]  rsp_rdata
);
  localparam int NW     = BUS_W / 32;
  localparam int MAX_SZ = $clog2(BUS_W / 8);

  logic             busy, done;
  logic             berr_q, roa_q;
  logic [2:0]       size_q, err_q;
  logic [AW-1:0]    addr_q;
  logic [BUS_W-1:0] data_q;

  logic is_stat, is_addr, is_data;
  logic [REG_AW-1:0] widx;
  logic busy_hit, wr_addr_ok, wr_data_ok, blocked;
  logic want_rd, want_wr, chk_ok, start, bad_start;
  logic [AW-1:0]    start_addr;
  logic [BUS_W-1:0] start_wdata;
  logic [NW-1:0]    word_wr;
  logic [31:0]      rd_word, stat_word;

  assign is_stat = (reg_addr == OFS_STAT);
  assign is_addr = (reg_addr == OFS_ADDR);
  assign is_data = (int'(reg_addr) >= OFS_DATA) && (int'(reg_addr) < OFS_DATA + NW);
  assign widx    = reg_addr - REG_AW'(OFS_DATA);

  assign busy_hit   = busy && ((reg_wr && (is_addr || is_data)) || (reg_rd && is_data));
  assign wr_addr_ok = reg_wr && is_addr && !busy;
  assign wr_data_ok = reg_wr && is_data && !busy;
  assign blocked    = berr_q || (err_q != ERR_NONE);
  assign want_rd    = wr_addr_ok && roa_q && !blocked;
  assign want_wr    = wr_data_ok && (widx == '0) && !blocked;
  assign start_addr = wr_addr_ok ? reg_wdata[AW-1:0] : addr_q;
  assign start      = (want_rd || want_wr) && chk_ok;
  assign bad_start  = (want_rd || want_wr) && !chk_ok;

  sbx_check #(.BUS_W(BUS_W)) u_check (
    .size    (size_q),
    .addr_lo (start_addr[3:0]),
    .ok      (chk_ok)
  );

  always_comb begin
    start_wdata = data_q;
    if (want_wr) start_wdata[31:0] = reg_wdata;
    for (int i = 0; i < NW; i++) word_wr[i] = wr_data_ok && (int'(widx) == i);
  end

  sbx_data #(.NW(NW)) u_data (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (word_wr),
    .wr_word   (reg_wdata),
    .load      (done && !rsp_err && !req_write),
    .load_data (rsp_rdata),
    .q         (data_q)
  );

  sbx_bus #(.BUS_W(BUS_W), .AW(AW)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .st_write  (want_wr),
    .st_addr   (start_addr),
    .st_size   (size_q),
    .st_wdata  (start_wdata),
    .rsp_valid (rsp_valid),
    .busy      (busy),
    .done      (done),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      berr_q <= 1'b0;
      roa_q  <= 1'b0;
      size_q <= '0;
      err_q  <= ERR_NONE;
      addr_q <= '0;
    end else begin
      if (wr_addr_ok) addr_q <= reg_wdata[AW-1:0];
      if (reg_wr && is_stat) begin
        roa_q  <= reg_wdata[B_ROA];
        size_q <= reg_wdata[B_SIZE +: 3];
      end
      if (busy_hit) berr_q <= 1'b1;
      else if (reg_wr && is_stat && reg_wdata[B_BERR]) berr_q <= 1'b0;
      if (done && rsp_err) err_q <= ERR_BAD;
      else if (bad_start)  err_q <= ERR_OTH;
      else if (reg_wr && is_stat) err_q <= err_q & ~reg_wdata[B_ERR +: 3];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NW; i++) if (int'(widx) == i) rd_word = data_q[i*32 +: 32];
    stat_word = {VERSION, 6'b0, berr_q, busy, roa_q, size_q, 2'b0, err_q, 12'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      if (is_stat)      reg_rdata <= stat_word;
      else if (is_addr) reg_rdata <= 32'(addr_q);
      else if (is_data) reg_rdata <= rd_word;
      else              reg_rdata <= '0;
    end
  end

  p_no_start_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(!berr_q && err_q == ERR_NONE));
  p_size_legal_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> int'(req_size) <= MAX_SZ);
  p_berr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    berr_q && !(reg_wr && is_stat && reg_wdata[B_BERR]) |=> berr_q);
  p_bus_err_code_r9: assert property (@(posedge clk) disable iff (rst)
    busy && rsp_valid && rsp_err |=> err_q == ERR_BAD && !busy);
  p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    busy && reg_wr && is_addr |=> $stable(addr_q) && berr_q);
endmodule

// File: tb/sbx_ctrl_test.sv
`timescale 1ns/1ps
module sbx_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [2:0]  req_size;
  logic [63:0] req_wdata;
  logic        rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [63:0] rsp_rdata = '0;

  sbx_ctrl uut (.*);

  always #2.5 clk = ~clk;

  typedef struct { bit w; logic [31:0] a; logic [2:0] s; logic [63:0] d; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_err = 0, lat = 3, cnt = 0;
  bit pend = 0, p_write = 0, finished = 0;
  logic [31:0] p_addr;
  logic [31:0] v;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(bit w, logic [31:0] a, logic [2:0] s, logic [63:0] d);
    exp_t e;
    e.w = w; e.a = a; e.s = s; e.d = d;
    q.push_back(e);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor + bus responder
  always @(negedge clk) begin
    rsp_valid = 1'b0;
    rsp_err   = 1'b0;
    if (!rst && pend) begin
      if (cnt == 0) begin
        rsp_valid = 1'b1;
        rsp_err   = (p_addr[31:28] == 4'hF);
        rsp_rdata = p_write ? 64'd0 : {~p_addr, p_addr ^ 32'h5A5A_0000};
        pend = 0;
      end else cnt--;
    end
    if (!rst && req_valid) begin
      n_chk++;
      if (q.size() == 0) begin
        n_err++;
        $display("FAIL R8 unexpected request act=%h exp=none", req_addr);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (req_write !== e.w || req_addr !== e.a || req_size !== e.s ||
            (e.w && req_wdata !== e.d)) begin
          n_err++;
          $display("FAIL R4/R5 request act=%b %h %0d %h exp=%b %h %0d %h",
                   req_write, req_addr, req_size, req_wdata, e.w, e.a, e.s, e.d);
        end
      end
      pend = 1; cnt = lat; p_addr = req_addr; p_write = req_write;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 req idle in reset", {31'd0, req_valid}, 32'd0);
    rst = 1'b0;
    rd(0, v); chk("R1 status reset", v, 32'h2000_0000);
    rd(1, v); chk("R1 addr reset", v, 32'h0);
    rd(2, v); chk("R1 data reset", v, 32'h0);

    // R2: status fields
    wr(0, 32'h0004_0000);
    rd(0, v); chk("R2 size readback", v, 32'h2004_0000);

    // R4 + R3: bus write
    lat = 4;
    wr(1, 32'h100);
    wr(3, 32'h1111_2222);
    push(1, 32'h100, 3'd2, 64'h1111_2222_CAFE_F00D);
    wr(2, 32'hCAFE_F00D);
    rd(0, v); chk("R3 busy during access", v, 32'h2024_0000);
    idle(8);
    rd(0, v); chk("R3 busy cleared", v, 32'h2004_0000);
    rd(2, v); chk("R4 data word kept", v, 32'hCAFE_F00D);

    // R5: read on address
    wr(0, 32'h0016_0000);
    rd(0, v); chk("R2 roa+size readback", v, 32'h2016_0000);
    push(0, 32'h208, 3'd3, '0);
    wr(1, 32'h208);
    idle(8);
    rd(2, v); chk("R5 read word0", v, 32'h5A5A_0208);
    rd(3, v); chk("R5 read word1", v, 32'hFFFF_FDF7);

    // R7: busy violation
    lat = 6;
    push(0, 32'h210, 3'd3, '0);
    wr(1, 32'h210);
    rd(2, v);
    wr(1, 32'h300);
    idle(10);
    rd(1, v); chk("R7 addr write while busy ignored", v, 32'h210);
    rd(0, v); chk("R7 busy violation flag", v, 32'h2056_0000);

    // R8: blocked by busy violation
    wr(1, 32'h218);
    idle(8);
    chk("R8 no request while flag set", q.size(), 0);
    rd(1, v); chk("R8 addr still stored", v, 32'h218);

    // R10: clear flag, retry
    wr(0, 32'h0056_0000);
    rd(0, v); chk("R10 flag cleared", v, 32'h2016_0000);
    lat = 2;
    push(0, 32'h218, 3'd3, '0);
    wr(1, 32'h218);
    idle(6);
    rd(2, v); chk("R5 retry read word0", v, 32'h5A5A_0218);

    // R6: unsupported size
    wr(0, 32'h0008_0000);
    wr(2, 32'h1);
    idle(4);
    rd(0, v); chk("R6 size too wide err=3", v, 32'h2008_3000);

    // R8: error field blocks
    wr(0, 32'h0004_0000);
    wr(2, 32'h5);
    idle(4);
    rd(0, v); chk("R8 err blocks access", v, 32'h2004_3000);
    wr(0, 32'h0004_7000);
    rd(0, v); chk("R10 err cleared", v, 32'h2004_0000);

    // R6: misaligned
    wr(1, 32'h102);
    wr(2, 32'h7);
    idle(4);
    rd(0, v); chk("R6 misaligned err=3", v, 32'h2004_3000);
    wr(0, 32'h0004_7000);

    // R9: bus error
    wr(1, 32'hF000_0000);
    wr(3, 32'h0);
    push(1, 32'hF000_0000, 3'd2, 64'h0000_0000_0000_BEEF);
    wr(2, 32'hBEEF);
    idle(8);
    rd(0, v); chk("R9 bus error err=2", v, 32'h2004_2000);
    rd(2, v); chk("R9 data untouched", v, 32'h0000_BEEF);
    chk("R4 all requests seen", q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule